// File: doc/BRIEF.md
# Compressed Control-Flow Instruction Expander

This block sits between instruction fetch and decode of a 32-bit core that accepts 16-bit compressed encodings. It looks at a 32-bit fetched word and decides from its two lowest bits whether the word holds a full-width instruction or a compressed one in its lower half. Full-width words go through untouched. Compressed words from the control-flow and load-immediate subset are rewritten into the exact 32-bit instruction they stand for. That subset is the unconditional jump, the jump-and-link, the register jump with and without link, the two compare-with-zero branches and the small-constant load.

The compressed forms store their offsets in a shuffled bit order. The expander gathers those bits back into proper offsets and re-encodes them in the jump, branch and immediate layouts of the full instruction set. Offsets count in halfwords, so a target only needs 2-byte alignment. The branch forms name a register through a 3-bit field that selects x8 to x15. Compressed encodings outside the subset, and the reserved encodings inside it, raise an illegal flag. The whole path is combinational, so the decoder sees the result in the same cycle.

Top module: `rvc_flow_expander`

## Requirements
- R1: A word whose bits [1:0] are 2'b11 appears unchanged on `instr_out`, with `is_comp` = 0 and `illegal` = 0.
- R2: With bits [1:0] = 01 and bits [15:13] = 101, the output is `jal x0`. The offset is sign-extended from bit 11, and its bits are taken from the input as off[11]=b12, off[10]=b8, off[9:8]=b10:9, off[7]=b6, off[6]=b7, off[5]=b2, off[4]=b11, off[3:1]=b5:3, off[0]=0.
- R3: With bits [1:0] = 01 and bits [15:13] = 001, the output is `jal x1` with the same offset as R2.
- R4: With bits [1:0] = 10, bits [15:12] = 1000 and bits [6:2] = 0, the output is `jalr x0, 0(rs1)` where rs1 = bits [11:7]. If rs1 = 0, or if bits [6:2] are nonzero, `illegal` = 1.
- R5: With bits [1:0] = 10, bits [15:12] = 1001, bits [6:2] = 0 and rs1 = bits [11:7] nonzero, the output is `jalr x1, 0(rs1)`. If bits [6:2] are nonzero, `illegal` = 1.
- R6: With bits [1:0] = 10, bits [15:12] = 1001 and bits [11:2] all zero, the output is ebreak (32'h00100073) and `illegal` = 0.
- R7: With bits [1:0] = 01 and bits [15:13] = 110 or 111, the output is `beq` or `bne` of register x(8 + bits[9:7]) against x0. The offset is sign-extended from bit 8, with off[8]=b12, off[7:6]=b6:5, off[5]=b2, off[4:3]=b11:10, off[2:1]=b4:3, off[0]=0.
- R8: With bits [1:0] = 01 and bits [15:13] = 010, the output is `addi rd, x0, imm`, where rd = bits [11:7] and imm = {b12, b6:2} sign-extended to 12 bits.
- R9: Every other compressed encoding (bits [1:0] not 11) sets `illegal` = 1 and drives `instr_out` = 0. `is_comp` = 1 for every compressed word, legal or not.
- R10: For a compressed word, bits [31:16] of `instr_in` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_in | input | 32 | Fetched word; the lower half holds the compressed form when bits [1:0] are not 11 |
| instr_out | output | 32 | Expanded or passed-through 32-bit instruction; zero when illegal |
| is_comp | output | 1 | Input held a compressed instruction |
| illegal | output | 1 | Compressed encoding reserved or outside the supported subset |

## Verification
Two of the block's functions can hit the same word at once. The linked register jump and ebreak share one opcode and funct4, and only the zero or nonzero register fields separate them. Likewise, every compressed expansion has to happen while unrelated data sits in the upper halfword. The bench walks all 65,536 lower-half values, each paired with a random upper half, so both overlaps are provoked on every encoding. A behavioural model rebuilt from the requirements judges each case. Directed words with hand-computed results pin down the ebreak, reserved register-jump and negative-constant cases.

// File: rtl/rvc_flow_expander.sv
module rvc_flow_expander (
  input  logic [31:0] instr_in,
  output logic [31:0] instr_out,
  output logic        is_comp,
  output logic        illegal
);
  logic [15:0] c;
  logic [20:0] joff;
  logic [12:0] boff;
  logic [11:0] limm;
  logic [4:0]  rsp, rs1f, rs2f;
  logic [31:0] w;
  logic        bad;

  assign c       = instr_in[15:0];
  assign is_comp = (c[1:0] != 2'b11);
  assign joff    = {{10{c[12]}}, c[8], c[10:9], c[6], c[7], c[2], c[11], c[5:3], 1'b0};
  assign boff    = {{5{c[12]}}, c[6:5], c[2], c[11:10], c[4:3], 1'b0};
  assign limm    = {{7{c[12]}}, c[6:2]};
  assign rsp     = {2'b01, c[9:7]};
  assign rs1f    = c[11:7];
  assign rs2f    = c[6:2];

  function automatic logic [31:0] jal_w(input logic [4:0] rd, input logic [20:0] o);
    return {o[20], o[10:1], o[11], o[19:12], rd, 7'b1101111};
  endfunction

  function automatic logic [31:0] br_w(input logic [2:0] f3, input logic [4:0] rs, input logic [12:0] o);
    return {o[12], o[10:5], 5'd0, rs, f3, o[4:1], o[11], 7'b1100011};
  endfunction

  function automatic logic [31:0] jalr_w(input logic [4:0] rd, input logic [4:0] rs);
    return {12'd0, rs, 3'b000, rd, 7'b1100111};
  endfunction

  always_comb begin
    bad = 1'b0;
    w   = 32'd0;
    if (!is_comp) begin
      w = instr_in;
    end else begin
      case ({c[1:0], c[15:13]})
        5'b01_101: w = jal_w(5'd0, joff);
        5'b01_001: w = jal_w(5'd1, joff);
        5'b01_110: w = br_w(3'b000, rsp, boff);
        5'b01_111: w = br_w(3'b001, rsp, boff);
        5'b01_010: w = {limm, 5'd0, 3'b000, rs1f, 7'b0010011};
        5'b10_100: begin
          if (rs2f != 5'd0)
            bad = 1'b1;
          else if (!c[12])
            if (rs1f == 5'd0) bad = 1'b1;
            else              w = jalr_w(5'd0, rs1f);
          else
            if (rs1f == 5'd0) w = 32'h0010_0073;
            else              w = jalr_w(5'd1, rs1f);
        end
        default: bad = 1'b1;
      endcase
    end
    if (bad) w = 32'd0;
  end

  assign instr_out = w;
  assign illegal   = bad;

  always_comb begin
    if (instr_in[1:0] == 2'b11)
      assert_passthru_R1: assert (instr_out == instr_in && !illegal && !is_comp);
    if (illegal)
      assert_illegal_zero_R9: assert (instr_out == 32'd0 && is_comp);
    if (is_comp && !illegal)
      assert_full_width_R2: assert (instr_out[1:0] == 2'b11);
    if (is_comp && !illegal && instr_out[6:0] == 7'b1100011)
      assert_branch_regs_R7: assert (instr_out[24:20] == 5'd0 && instr_out[19:18] == 2'b01
                                     && instr_out[14:13] == 2'b00);
    if (is_comp && !illegal && instr_out[6:0] == 7'b1100111)
      assert_jalr_src_R4: assert (instr_out[19:15] != 5'd0 && instr_out[11:8] == 4'd0
                                  && instr_out[31:20] == 12'd0);
    if (is_comp && !illegal && instr_out[6:0] == 7'b1101111)
      assert_jal_link_R3: assert (instr_out[11:8] == 4'd0);
  end
endmodule

// File: tb/sim_rvc_flow_expander.sv
module sim_rvc_flow_expander;
  logic        clk = 1'b0;
  logic [31:0] din = 32'h0000_0013;
  logic [31:0] dout;
  logic        comp, ill;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rvc_flow_expander u0 (.instr_in(din), .instr_out(dout), .is_comp(comp), .illegal(ill));

  function automatic int bit_of(int v, int p);
    return (v >> p) & 1;
  endfunction

  function automatic logic [31:0] enc_j(int rd, int off);
    logic [20:0] o;
    o = off[20:0];
    return {o[20], o[10:1], o[11], o[19:12], rd[4:0], 7'h6f};
  endfunction

  function automatic logic [31:0] enc_b(int f3, int rs, int off);
    logic [12:0] o;
    o = off[12:0];
    return {o[12], o[10:5], 5'd0, rs[4:0], f3[2:0], o[4:1], o[11], 7'h63};
  endfunction

  task automatic model(input logic [31:0] x, output logic [31:0] eo, output bit ec,
                       output bit ei, output string tag);
    int h, q, f3, off, r1, r2;
    h = int'(x[15:0]);
    q = h & 3; f3 = (h >> 13) & 7;
    r1 = (h >> 7) & 31; r2 = (h >> 2) & 31;
    eo = 32'd0; ec = 1; ei = 1; tag = "R9";
    if (q == 3) begin
      eo = x; ec = 0; ei = 0; tag = "R1";
    end else if (q == 1 && (f3 == 5 || f3 == 1)) begin
      off = bit_of(h,12)*2048 + bit_of(h,8)*1024 + ((h>>9)&3)*256 + bit_of(h,6)*128
          + bit_of(h,7)*64 + bit_of(h,2)*32 + bit_of(h,11)*16 + ((h>>3)&7)*2;
      if (off >= 2048) off -= 4096;
      eo = enc_j(f3 == 1 ? 1 : 0, off); ei = 0; tag = (f3 == 1) ? "R3" : "R2";
    end else if (q == 1 && (f3 == 6 || f3 == 7)) begin
      off = bit_of(h,12)*256 + ((h>>5)&3)*64 + bit_of(h,2)*32 + ((h>>10)&3)*8 + ((h>>3)&3)*2;
      if (off >= 256) off -= 512;
      eo = enc_b(f3 - 6, 8 + ((h >> 7) & 7), off); ei = 0; tag = "R7";
    end else if (q == 1 && f3 == 2) begin
      off = bit_of(h,12)*32 + r2;
      if (off >= 32) off -= 64;
      eo = {off[11:0], 5'd0, 3'd0, r1[4:0], 7'h13}; ei = 0; tag = "R8";
    end else if (q == 2 && f3 == 4) begin
      if (bit_of(h,12) == 0) begin
        tag = "R4";
        if (r2 == 0 && r1 != 0) begin eo = {12'd0, r1[4:0], 3'd0, 5'd0, 7'h67}; ei = 0; end
      end else if (r2 == 0 && r1 == 0) begin
        eo = 32'h0010_0073; ei = 0; tag = "R6";
      end else begin
        tag = "R5";
        if (r2 == 0) begin eo = {12'd0, r1[4:0], 3'd0, 5'd1, 7'h67}; ei = 0; end
      end
    end
  endtask

  task automatic apply(input logic [31:0] x, input string extra);
    logic [31:0] eo; bit ec, ei; string tag;
    @(posedge clk);
    din = x;
    @(negedge clk);
    model(x, eo, ec, ei, tag);
    checks++;
    if (dout !== eo || comp !== ec || ill !== ei) begin
      errors++;
      $display("FAIL %s%s in=%h out=%h/%b/%b expected=%h/%b/%b",
               tag, extra, x, dout, comp, ill, eo, ec, ei);
    end
  endtask

  task automatic fixed(input logic [31:0] x, input logic [31:0] eo, input bit ei, input string tag);
    @(posedge clk);
    din = x;
    @(negedge clk);
    checks++;
    if (dout !== eo || ill !== ei) begin
      errors++;
      $display("FAIL %s in=%h out=%h ill=%b expected=%h ill=%b", tag, x, dout, ill, eo, ei);
    end
  endtask

  initial begin
    fixed(32'h0000_0013, 32'h0000_0013, 0, "R1 reset-state nop");
    fixed(32'h0000_8082, 32'h0000_8067, 0, "R4 jr x1");
    fixed(32'h0000_8002, 32'h0000_0000, 1, "R4 reserved jr x0");
    fixed(32'h0000_9282, 32'h0002_80E7, 0, "R5 jalr x5");
    fixed(32'h0000_9286, 32'h0000_0000, 1, "R5 rs2 nonzero");
    fixed(32'hABCD_9002, 32'h0010_0073, 0, "R6 ebreak");
    fixed(32'h0000_557D, 32'hFFF0_0513, 0, "R8 li a0,-1");
    fixed(32'h1234_4515, 32'h0050_0513, 0, "R8 li a0,5 R10");
    fixed(32'h0000_0000, 32'h0000_0000, 1, "R9 all-zero");
    for (int i = 0; i < 65536; i++)
      apply({$urandom()} << 16 | i, " sweep R10");
    for (int i = 0; i < 2000; i++)
      apply({$urandom()} | 32'h3, " R1 random");
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule